// File: doc/BRIEF.md
# Three-Phase Reset-Synchronized PWM Generator

The block produces three phases of edge-aligned PWM from one shared up-counter. The counter runs from zero up to the value held in a period register and then clears to zero. Each phase has a compare register. Its positive output is active from the start of the cycle until the counter reaches that phase's compare value. Its negative output is the complement of the positive output. One polarity bit applies to all three positive outputs and a second polarity bit applies to all three negative outputs. Each output has its own enable bit. An optional seventh output toggles once at the end of every PWM cycle.

Software sets the block up through a flat 16-bit register port while counting is halted, then raises `run_i`. While `run_i` is high the configuration is locked. Lowering `run_i` returns the counter and prescaler to zero and drives every phase output to its inactive level. A prescaler divides the system clock by 1, 4, 16 or 64 to produce the counting tick.

Register map (word addresses): 0 period, 1..3 compare for phases 0..2, 4 control, 5 output enables.

Top module: `pwm3_top`

## Requirements
- R1: On each prescaler tick while running, the counter advances by one. A tick that finds the counter equal to the period register clears the counter to 0, so one PWM cycle lasts (period+1) ticks.
- R2: Control bits [1:0] select the tick rate: code 0 gives one tick every clock, and codes 1, 2 and 3 give one tick every 4, 16 and 64 clocks. The first tick falls on the (divide)th rising edge after `run_i` is sampled high.
- R3: The active state of a phase is registered from the counter. After the rising edge at which the counter holds value c, phase i is active when c < compare_i. It is inactive otherwise.
- R4: When compare_i equals the period value, phase i is active for the whole cycle (100% duty).
- R5: While running, each negative output carries the complement of its phase's active state before polarity is applied.
- R6: Control bit 2 sets the active level of the positive outputs and control bit 3 sets the active level of the negative outputs. 1 means active high and 0 means active low. An inactive output drives the opposite level.
- R7: Enable register bits [2:0] gate the positive outputs of phases 0..2, bits [5:3] gate the negative outputs, and bit 6 gates the toggle output. A disabled phase output drives its inactive level. A disabled toggle output drives 0.
- R8: When control bit 4 is set, the toggle output flips on every tick that clears the counter. When control bit 4 is clear, the toggle output holds its level.
- R9: Writes are accepted only while `run_i` is low. A write while running leaves the register unchanged. All six registers read back on `rd_data_o` combinationally from `rd_addr_i`, and unused addresses read 0.
- R10: One clock after `run_i` is sampled low, the counter is zero and all six phase outputs drive their inactive levels.
- R11: After reset, all registers are 0 except control, which reads 0x000C. With that control value all seven outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Count enable. High runs the counter, low halts it and clears it |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data, combinational |
| pos_o | output | 3 | Positive phase outputs, phases 0..2 |
| neg_o | output | 3 | Negative phase outputs, phases 0..2 |
| tgl_o | output | 1 | Cycle-synchronized toggle output |

## Verification
With `run_i` raised just after a falling edge, the rising edge numbered k from zero sees counter value floor(k/divide) mod (period+1). The phase outputs therefore reflect that value right after edge k, one register stage later. The toggle output flips right after the edge on which a tick meets the counter at the period value. The bench keeps its own edge counter from that model. It samples all seven outputs at the falling edge following each rising edge. Register reads are combinational, so they are checked one time unit after the address changes. The halted state is checked at the falling edge after the first edge that samples `run_i` low.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int unsigned CTRL_PSC_LSB = 0;
  localparam int unsigned CTRL_POL_P   = 2;
  localparam int unsigned CTRL_POL_N   = 3;
  localparam int unsigned CTRL_TGL_EN  = 4;

  typedef struct packed {
    logic       tgl_en;
    logic       pol_n;
    logic       pol_p;
    logic [1:0] psc_sel;
  } pwm_cfg_t;

  localparam pwm_cfg_t CFG_RESET = '{tgl_en: 1'b0, pol_n: 1'b1, pol_p: 1'b1, psc_sel: 2'd0};
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_PH   = 3,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned OE_W   = 2 * N_PH + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       lock_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [CNT_W-1:0]           wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [CNT_W-1:0]           rd_data_o,
  output logic [CNT_W-1:0]           period_o,
  output logic [N_PH-1:0][CNT_W-1:0] cmp_o,
  output pwm_cfg_t                   cfg_o,
  output logic [OE_W-1:0]            oe_o
);
  localparam logic [ADDR_W-1:0] A_PERIOD = '0;
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(N_PH + 1);
  localparam logic [ADDR_W-1:0] A_OE     = ADDR_W'(N_PH + 2);

  logic wr_ok;
  assign wr_ok = wr_en_i && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= '0;
      cfg_o    <= CFG_RESET;
      oe_o     <= '0;
    end else if (wr_ok) begin
      if (wr_addr_i == A_PERIOD) period_o <= wr_data_i;
      if (wr_addr_i == A_CTRL) begin
        cfg_o.psc_sel <= wr_data_i[CTRL_PSC_LSB +: 2];
        cfg_o.pol_p   <= wr_data_i[CTRL_POL_P];
        cfg_o.pol_n   <= wr_data_i[CTRL_POL_N];
        cfg_o.tgl_en  <= wr_data_i[CTRL_TGL_EN];
      end
      if (wr_addr_i == A_OE) oe_o <= wr_data_i[OE_W-1:0];
    end
  end

  for (genvar i = 0; i < N_PH; i++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     cmp_o[i] <= '0;
      else if (wr_ok && wr_addr_i == ADDR_W'(i + 1))   cmp_o[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_PERIOD) rd_data_o = period_o;
    for (int i = 0; i < N_PH; i++)
      if (rd_addr_i == ADDR_W'(i + 1)) rd_data_o = cmp_o[i];
    if (rd_addr_i == A_CTRL) begin
      rd_data_o[CTRL_PSC_LSB +: 2] = cfg_o.psc_sel;
      rd_data_o[CTRL_POL_P]        = cfg_o.pol_p;
      rd_data_o[CTRL_POL_N]        = cfg_o.pol_n;
      rd_data_o[CTRL_TGL_EN]       = cfg_o.tgl_en;
    end
    if (rd_addr_i == A_OE) rd_data_o[OE_W-1:0] = oe_o;
  end
endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       psc_sel_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             wrap_o
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_mask;

  // divide 4**sel: low 2*sel bits all ones marks the tick
  always_comb begin
    psc_mask = '0;
    for (int b = 0; b < PSC_W; b++)
      if (b < 2 * int'(psc_sel_i)) psc_mask[b] = 1'b1;
  end

  assign tick_o = run_i && ((psc_q & psc_mask) == psc_mask);
  assign wrap_o = tick_o && (cnt_o == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (!run_i) psc_q <= '0;
    else             psc_q <= psc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (!run_i) cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else if (tick_o) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             act_p_o,
  output logic             act_n_o
);
  logic act_d;
  // compare equal to period keeps the phase on across the wrap
  assign act_d = (cnt_i < cmp_i) || (cmp_i == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_p_o <= 1'b0;
      act_n_o <= 1'b0;
    end else if (!run_i) begin
      act_p_o <= 1'b0;
      act_n_o <= 1'b0;
    end else begin
      act_p_o <= act_d;
      act_n_o <= !act_d;
    end
  end
endmodule

// File: rtl/pwm3_out.sv
module pwm3_out #(
  parameter int unsigned N_PH = 3,
  parameter int unsigned OE_W = 2 * N_PH + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wrap_i,
  input  logic            tgl_en_i,
  input  logic            pol_p_i,
  input  logic            pol_n_i,
  input  logic [OE_W-1:0] oe_i,
  input  logic [N_PH-1:0] act_p_i,
  input  logic [N_PH-1:0] act_n_i,
  output logic [N_PH-1:0] pos_o,
  output logic [N_PH-1:0] neg_o,
  output logic            tgl_o,
  output logic            tgl_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tgl_q_o <= 1'b0;
    else if (wrap_i && tgl_en_i) tgl_q_o <= !tgl_q_o;
  end

  for (genvar i = 0; i < N_PH; i++) begin : g_drv
    assign pos_o[i] = (act_p_i[i] && oe_i[i])        ? pol_p_i : !pol_p_i;
    assign neg_o[i] = (act_n_i[i] && oe_i[N_PH + i]) ? pol_n_i : !pol_n_i;
  end

  assign tgl_o = oe_i[2 * N_PH] && tgl_q_o;
endmodule

// File: rtl/pwm3_top.sv
module pwm3_top
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_PH   = 3,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned PSC_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic [N_PH-1:0]   pos_o,
  output logic [N_PH-1:0]   neg_o,
  output logic              tgl_o
);
  localparam int unsigned OE_W = 2 * N_PH + 1;

  logic [CNT_W-1:0]           period_w;
  logic [N_PH-1:0][CNT_W-1:0] cmp_w;
  pwm_cfg_t                   cfg_w;
  logic [OE_W-1:0]            oe_w;
  logic [CNT_W-1:0]           cnt_w;
  logic                       tick_w;
  logic                       wrap_w;
  logic [N_PH-1:0]            act_p_w;
  logic [N_PH-1:0]            act_n_w;
  logic                       tgl_q_w;

  pwm3_regs #(.CNT_W(CNT_W), .N_PH(N_PH), .ADDR_W(ADDR_W), .OE_W(OE_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (run_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .period_o  (period_w),
    .cmp_o     (cmp_w),
    .cfg_o     (cfg_w),
    .oe_o      (oe_w)
  );

  pwm3_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .psc_sel_i (cfg_w.psc_sel),
    .period_i  (period_w),
    .cnt_o     (cnt_w),
    .tick_o    (tick_w),
    .wrap_o    (wrap_w)
  );

  for (genvar i = 0; i < N_PH; i++) begin : g_ph
    pwm3_phase #(.CNT_W(CNT_W)) u_ph (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_i),
      .cnt_i    (cnt_w),
      .cmp_i    (cmp_w[i]),
      .period_i (period_w),
      .act_p_o  (act_p_w[i]),
      .act_n_o  (act_n_w[i])
    );
  end

  pwm3_out #(.N_PH(N_PH), .OE_W(OE_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap_w),
    .tgl_en_i (cfg_w.tgl_en),
    .pol_p_i  (cfg_w.pol_p),
    .pol_n_i  (cfg_w.pol_n),
    .oe_i     (oe_w),
    .act_p_i  (act_p_w),
    .act_n_i  (act_n_w),
    .pos_o    (pos_o),
    .neg_o    (neg_o),
    .tgl_o    (tgl_o),
    .tgl_q_o  (tgl_q_w)
  );
endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_PH  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             tick,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic [N_PH-1:0]  act_p,
  input logic [N_PH-1:0]  act_n,
  input logic             tgl_en,
  input logic             tgl_q,
  input logic             pol_p,
  input logic             pol_n,
  input logic [N_PH-1:0]  pos_o,
  input logic [N_PH-1:0]  neg_o
);
  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt <= period);

  assert_wrap_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && wrap) |=> cnt == '0);

  assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && !wrap) |=> cnt == $past(cnt) + 1'b1);

  assert_compl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (act_p ^ act_n) == {N_PH{1'b1}});

  assert_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(period));

  assert_tgl_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgl_en |=> $stable(tgl_q));

  assert_halt_cnt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt == '0);

  assert_halt_out_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pos_o == {N_PH{!pol_p}}) && (neg_o == {N_PH{!pol_n}}));
endmodule

bind pwm3_top pwm3_chk #(.CNT_W(CNT_W), .N_PH(N_PH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_i  (run_i),
  .tick   (tick_w),
  .wrap   (wrap_w),
  .cnt    (cnt_w),
  .period (period_w),
  .act_p  (act_p_w),
  .act_n  (act_n_w),
  .tgl_en (cfg_w.tgl_en),
  .tgl_q  (tgl_q_w),
  .pol_p  (cfg_w.pol_p),
  .pol_n  (cfg_w.pol_n),
  .pos_o  (pos_o),
  .neg_o  (neg_o)
);

// File: tb/tb_pwm3_top.sv
`timescale 1ns/1ps
module tb_pwm3_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [2:0]  pos, neg;
  logic        tgl;

  int checks = 0;
  int errors = 0;
  logic tgl_m = 1'b0;

  always #2 clk = !clk;

  pwm3_top dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pos_o(pos), .neg_o(neg), .tgl_o(tgl)
  );

  typedef struct packed {
    logic [15:0] period;
    logic [15:0] c0;
    logic [15:0] c1;
    logic [15:0] c2;
    logic [1:0]  psc;
    logic        pp;
    logic        pn;
    logic        ten;
    logic [6:0]  oe;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd9, 16'd3, 16'd5, 16'd9, 2'd0, 1'b1, 1'b1, 1'b1, 7'h7F, 16'd40},
    '{16'd4, 16'd0, 16'd2, 16'd4, 2'd1, 1'b0, 1'b1, 1'b1, 7'h7F, 16'd60},
    '{16'd3, 16'd1, 16'd1, 16'd3, 2'd2, 1'b1, 1'b0, 1'b0, 7'h55, 16'd140},
    '{16'd1, 16'd0, 16'd1, 16'd1, 2'd3, 1'b1, 1'b1, 1'b1, 7'h7F, 16'd300},
    '{16'd0, 16'd0, 16'd0, 16'd0, 2'd0, 1'b1, 1'b1, 1'b1, 7'h7F, 16'd10},
    '{16'd7, 16'd2, 16'd4, 16'd6, 2'd0, 1'b0, 1'b0, 1'b1, 7'h2A, 16'd30}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic run_vec(input vec_t v);
    int d;
    logic [15:0] cmp [3];
    logic [2:0] ep, en;
    wr(3'd0, v.period); wr(3'd1, v.c0); wr(3'd2, v.c1); wr(3'd3, v.c2);
    wr(3'd4, {11'd0, v.ten, v.pn, v.pp, v.psc});
    wr(3'd5, {9'd0, v.oe});
    cmp[0] = v.c0; cmp[1] = v.c1; cmp[2] = v.c2;
    d = 1 << (2 * int'(v.psc));
    @(negedge clk);
    run = 1'b1;
    for (int k = 0; k < int'(v.n); k++) begin
      int c;
      @(posedge clk);
      c = (k / d) % (int'(v.period) + 1);
      if (v.ten && (k % d == d - 1) && c == int'(v.period)) tgl_m = !tgl_m;
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        logic a;
        a = (c < int'(cmp[i])) || (cmp[i] == v.period);
        ep[i] = (a && v.oe[i])     ? v.pp : !v.pp;
        en[i] = (!a && v.oe[3 + i]) ? v.pn : !v.pn;
      end
      chk("R1 R2 R3 R4 R6 R7 pos", {29'd0, pos}, {29'd0, ep});
      chk("R5 R6 R7 neg", {29'd0, neg}, {29'd0, en});
      chk("R7 R8 tgl", {31'd0, tgl}, {31'd0, v.oe[6] && tgl_m});
    end
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 pos", {29'd0, pos}, 32'd0);
    chk("R11 neg", {29'd0, neg}, 32'd0);
    chk("R11 tgl", {31'd0, tgl}, 32'd0);
    rd(3'd4, r); chk("R11 ctrl", {16'd0, r}, 32'h000C);
    rd(3'd0, r); chk("R11 period", {16'd0, r}, 32'd0);
    // R9 readback while halted
    wr(3'd0, 16'h1234); rd(3'd0, r); chk("R9 period rb", {16'd0, r}, 32'h1234);
    wr(3'd2, 16'h0042); rd(3'd2, r); chk("R9 cmp1 rb", {16'd0, r}, 32'h0042);
    rd(3'd6, r); chk("R9 unused addr", {16'd0, r}, 32'd0);
    // R9 writes while running are dropped
    wr(3'd0, 16'd20);
    wr(3'd5, 16'h007F);
    @(negedge clk); run = 1'b1;
    repeat (3) @(negedge clk);
    wr(3'd0, 16'd5);
    wr(3'd5, 16'h0000);
    wr(3'd4, 16'h0010);
    run = 1'b0;
    @(negedge clk);
    rd(3'd0, r); chk("R9 period locked", {16'd0, r}, 32'd20);
    rd(3'd5, r); chk("R9 enable locked", {16'd0, r}, 32'h007F);
    rd(3'd4, r); chk("R9 ctrl locked", {16'd0, r}, 32'h000C);
    // R10 halted outputs inactive, both polarities
    chk("R10 pos halted", {29'd0, pos}, 32'd0);
    chk("R10 neg halted", {29'd0, neg}, 32'd0);
    wr(3'd4, 16'h0000);
    @(negedge clk);
    chk("R10 R6 pos halted low-active", {29'd0, pos}, 32'd7);
    chk("R10 R6 neg halted low-active", {29'd0, neg}, 32'd7);
    // table walk
    for (int j = 0; j < 6; j++) run_vec(VECS[j]);
    // R8 hold with toggle disabled after running
    wr(3'd4, 16'h000C);
    wr(3'd5, 16'h0040);
    @(negedge clk); run = 1'b1;
    repeat (12) @(negedge clk);
    chk("R8 tgl hold", {31'd0, tgl}, {31'd0, tgl_m});
    run = 1'b0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule